// File: doc/BRIEF.md
# Dual-Port Prioritised Address Window Translator

This block maps logical addresses to physical addresses for two requesters at once: an instruction-fetch port and a data-access port. Each port has its own bank of four programmable windows. A window compares selected logical address bits with a base. On a match it substitutes a physical base for those bits, names the external device behind the window, and gives a wait-state count. Windows may overlap, and the lowest-numbered enabled window that matches wins. An address that no enabled window claims is passed to internal memory unchanged, with no wait states.

Both ports are translated in the same cycle. A port that has been granted keeps its external device until its ready pulse. Two ports that reach for the same device are serialised: the data port wins a tie in the same cycle, and a port whose device is already held waits. A requester raises its request and holds the address steady. Ready then comes exactly the window's wait count of cycles after the grant. Windows are loaded one field at a time through a small write port.

Top module: `win_xlate`

## Requirements
- R1: After reset every window is disabled, so both ports give `paddr` equal to the zero-extended `laddr`, `ext` low and `dev` zero.
- R2: A window matches when `(laddr & mask) == (lbase & mask)` and it is enabled; a mask bit of 1 marks a compared bit. On a match `paddr = pbase | (laddr & ~mask)`, `ext` is high and `dev` is the window's device.
- R3: When several enabled windows of one port match, the lowest-numbered one gives the translation.
- R4: A disabled window never matches, whatever its other fields hold.
- R5: The write port selects the bank with `cfg_port` (0 = fetch, 1 = data) and the window with `cfg_idx`; a write to one bank leaves the other bank's translations unchanged.
- R6: Both ports present their translations combinationally in the same cycle, independent of `req`.
- R7: A granted request with wait count W gets `ready` exactly W cycles after the grant cycle (W = 0: in the grant cycle). The requester holds `req` and `laddr` until it sees `ready`.
- R8: An address that misses all enabled windows is granted at once and gets `ready` in the cycle of the request.
- R9: When both ports newly request the same external device in one cycle, the data port is granted and the fetch port stalls. The fetch port is granted in the cycle after the data port's `ready`.
- R10: While a port's access to a device is in progress, through its `ready` cycle, the other port's request to that device stalls. Requests to different devices proceed concurrently.
- R11: `cfg_fld` picks the field: 0 logical base (`cfg_wdata[LA_W-1:0]`), 1 mask, 2 physical base (`cfg_wdata[PA_W-1:0]`), 3 control (bits [1:0] device, [5:2] wait count, bit 6 enable, for the default widths). A write takes effect at the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Window field write strobe |
| cfg_port | input | 1 | Bank select: 0 fetch, 1 data |
| cfg_idx | input | IDX_W | Window number within the bank |
| cfg_fld | input | 2 | Field select |
| cfg_wdata | input | CFG_W | Field write value |
| c_req | input | 1 | Fetch port request |
| c_laddr | input | LA_W | Fetch port logical address |
| c_paddr | output | PA_W | Fetch port physical address |
| c_dev | output | DEV_W | Fetch port device number |
| c_ext | output | 1 | Fetch port hit an external window |
| c_ready | output | 1 | Fetch port access complete |
| d_req | input | 1 | Data port request |
| d_laddr | input | LA_W | Data port logical address |
| d_paddr | output | PA_W | Data port physical address |
| d_dev | output | DEV_W | Data port device number |
| d_ext | output | 1 | Data port hit an external window |
| d_ready | output | 1 | Data port access complete |

## Verification
If a wait counter holds a wrong value, `ready` comes early or late. That error shows on the very transaction in progress, as a latency different from the programmed count. If a held-device record is lost or wrong, the other port is released during a live access to the same device. This shows within one cycle as an early `ready` on the stalled port. A bad window register or priority selection changes `paddr` or `dev` at once, in the same cycle the address is driven. For that reason every completion is compared for address, device and exact latency.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    // field select codes of the window write port
    typedef enum logic [1:0] {
        FLD_LBASE = 2'd0,
        FLD_MASK  = 2'd1,
        FLD_PBASE = 2'd2,
        FLD_CTRL  = 2'd3
    } xlt_fld_e;

    localparam int NPORT     = 2;
    localparam int PORT_CODE = 0;
    localparam int PORT_DATA = 1;
endpackage

// File: rtl/xlt_regfile.sv
module xlt_regfile #(
    parameter int NWIN   = 4,
    parameter int LA_W   = 16,
    parameter int PA_W   = 24,
    parameter int DEV_W  = 2,
    parameter int WAIT_W = 4,
    parameter int CFG_W  = 32,
    parameter int IDX_W  = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cfg_we,
    input  logic                                          cfg_port,
    input  logic [IDX_W-1:0]                              cfg_idx,
    input  logic [1:0]                                    cfg_fld,
    input  logic [CFG_W-1:0]                              cfg_wdata,
    output logic [xlt_pkg::NPORT-1:0][NWIN-1:0]           en,
    output logic [xlt_pkg::NPORT-1:0][NWIN-1:0][LA_W-1:0] lbase,
    output logic [xlt_pkg::NPORT-1:0][NWIN-1:0][LA_W-1:0] mask,
    output logic [xlt_pkg::NPORT-1:0][NWIN-1:0][PA_W-1:0] pbase,
    output logic [xlt_pkg::NPORT-1:0][NWIN-1:0][DEV_W-1:0] dev,
    output logic [xlt_pkg::NPORT-1:0][NWIN-1:0][WAIT_W-1:0] wt
);
    import xlt_pkg::*;

    localparam int EN_BIT = DEV_W + WAIT_W;

    typedef struct packed {
        logic [NPORT-1:0][NWIN-1:0]              en;
        logic [NPORT-1:0][NWIN-1:0][LA_W-1:0]    lbase;
        logic [NPORT-1:0][NWIN-1:0][LA_W-1:0]    mask;
        logic [NPORT-1:0][NWIN-1:0][PA_W-1:0]    pbase;
        logic [NPORT-1:0][NWIN-1:0][DEV_W-1:0]   dev;
        logic [NPORT-1:0][NWIN-1:0][WAIT_W-1:0]  wt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (xlt_fld_e'(cfg_fld))
                FLD_LBASE: r_d.lbase[cfg_port][cfg_idx] = cfg_wdata[LA_W-1:0];
                FLD_MASK:  r_d.mask[cfg_port][cfg_idx]  = cfg_wdata[LA_W-1:0];
                FLD_PBASE: r_d.pbase[cfg_port][cfg_idx] = cfg_wdata[PA_W-1:0];
                default: begin
                    r_d.dev[cfg_port][cfg_idx] = cfg_wdata[DEV_W-1:0];
                    r_d.wt[cfg_port][cfg_idx]  = cfg_wdata[DEV_W +: WAIT_W];
                    r_d.en[cfg_port][cfg_idx]  = cfg_wdata[EN_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en    = r_q.en;
    assign lbase = r_q.lbase;
    assign mask  = r_q.mask;
    assign pbase = r_q.pbase;
    assign dev   = r_q.dev;
    assign wt    = r_q.wt;
endmodule

// File: rtl/xlt_match.sv
module xlt_match #(
    parameter int NWIN   = 4,
    parameter int LA_W   = 16,
    parameter int PA_W   = 24,
    parameter int DEV_W  = 2,
    parameter int WAIT_W = 4
) (
    input  logic [LA_W-1:0]               laddr,
    input  logic [NWIN-1:0]               en,
    input  logic [NWIN-1:0][LA_W-1:0]     lbase,
    input  logic [NWIN-1:0][LA_W-1:0]     mask,
    input  logic [NWIN-1:0][PA_W-1:0]     pbase,
    input  logic [NWIN-1:0][DEV_W-1:0]    dev,
    input  logic [NWIN-1:0][WAIT_W-1:0]   wt,
    output logic                          hit,
    output logic [PA_W-1:0]               paddr,
    output logic [DEV_W-1:0]              dev_o,
    output logic [WAIT_W-1:0]             wt_o
);
    logic [NWIN-1:0] win_hit;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        assign win_hit[w] = en[w] && ((laddr & mask[w]) == (lbase[w] & mask[w]));
    end

    // scan from the lowest priority upward so the lowest index is applied last
    always_comb begin
        hit   = 1'b0;
        paddr = PA_W'(laddr);
        dev_o = '0;
        wt_o  = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (win_hit[w]) begin
                hit   = 1'b1;
                paddr = pbase[w] | PA_W'(laddr & ~mask[w]);
                dev_o = dev[w];
                wt_o  = wt[w];
            end
        end
    end
endmodule

// File: rtl/xlt_waitctl.sv
module xlt_waitctl #(
    parameter int DEV_W  = 2,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              ext,
    input  logic [WAIT_W-1:0] wt_in,
    input  logic [DEV_W-1:0]  dev_in,
    output logic              busy,
    output logic [DEV_W-1:0]  held_dev,
    output logic              ready
);
    typedef struct packed {
        logic              busy;
        logic [WAIT_W-1:0] cnt;
        logic [DEV_W-1:0]  dev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) st_d.busy = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end else if (grant && ext && wt_in != '0) begin
            st_d.busy = 1'b1;
            st_d.cnt  = wt_in - 1'b1;
            st_d.dev  = dev_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign held_dev = st_q.dev;
    assign ready    = (st_q.busy && st_q.cnt == '0)
                   || (!st_q.busy && grant && (!ext || wt_in == '0));
endmodule

// File: rtl/win_xlate.sv
module win_xlate #(
    parameter  int NWIN   = 4,
    parameter  int LA_W   = 16,
    parameter  int PA_W   = 24,
    parameter  int DEV_W  = 2,
    parameter  int WAIT_W = 4,
    parameter  int CFG_W  = 32,
    localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_port,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_fld,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              c_req,
    input  logic [LA_W-1:0]   c_laddr,
    output logic [PA_W-1:0]   c_paddr,
    output logic [DEV_W-1:0]  c_dev,
    output logic              c_ext,
    output logic              c_ready,
    input  logic              d_req,
    input  logic [LA_W-1:0]   d_laddr,
    output logic [PA_W-1:0]   d_paddr,
    output logic [DEV_W-1:0]  d_dev,
    output logic              d_ext,
    output logic              d_ready
);
    import xlt_pkg::*;

    logic [NPORT-1:0][NWIN-1:0]              en;
    logic [NPORT-1:0][NWIN-1:0][LA_W-1:0]    lbase;
    logic [NPORT-1:0][NWIN-1:0][LA_W-1:0]    mask;
    logic [NPORT-1:0][NWIN-1:0][PA_W-1:0]    pbase;
    logic [NPORT-1:0][NWIN-1:0][DEV_W-1:0]   wdev;
    logic [NPORT-1:0][NWIN-1:0][WAIT_W-1:0]  wwt;

    logic [NPORT-1:0]              req_a;
    logic [NPORT-1:0][LA_W-1:0]    la_a;
    logic [NPORT-1:0]              hit_a;
    logic [NPORT-1:0][PA_W-1:0]    pa_a;
    logic [NPORT-1:0][DEV_W-1:0]   dev_a;
    logic [NPORT-1:0][WAIT_W-1:0]  wt_a;
    logic [NPORT-1:0]              busy;
    logic [NPORT-1:0][DEV_W-1:0]   hdev;
    logic [NPORT-1:0]              grant;
    logic [NPORT-1:0]              rdy;

    xlt_regfile #(
        .NWIN(NWIN), .LA_W(LA_W), .PA_W(PA_W), .DEV_W(DEV_W),
        .WAIT_W(WAIT_W), .CFG_W(CFG_W), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
        .en(en), .lbase(lbase), .mask(mask), .pbase(pbase), .dev(wdev), .wt(wwt)
    );

    assign req_a[PORT_CODE] = c_req;
    assign req_a[PORT_DATA] = d_req;
    assign la_a[PORT_CODE]  = c_laddr;
    assign la_a[PORT_DATA]  = d_laddr;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xlt_match #(
            .NWIN(NWIN), .LA_W(LA_W), .PA_W(PA_W), .DEV_W(DEV_W), .WAIT_W(WAIT_W)
        ) u_match (
            .laddr(la_a[p]), .en(en[p]), .lbase(lbase[p]), .mask(mask[p]),
            .pbase(pbase[p]), .dev(wdev[p]), .wt(wwt[p]),
            .hit(hit_a[p]), .paddr(pa_a[p]), .dev_o(dev_a[p]), .wt_o(wt_a[p])
        );

        xlt_waitctl #(.DEV_W(DEV_W), .WAIT_W(WAIT_W)) u_wait (
            .clk(clk), .rst_n(rst_n), .grant(grant[p]), .ext(hit_a[p]),
            .wt_in(wt_a[p]), .dev_in(dev_a[p]),
            .busy(busy[p]), .held_dev(hdev[p]), .ready(rdy[p])
        );
    end

    // device arbitration: data wins a same-cycle tie, a held device blocks the other port
    always_comb begin
        logic d_block, c_block;
        d_block = hit_a[PORT_DATA] && busy[PORT_CODE]
               && (hdev[PORT_CODE] == dev_a[PORT_DATA]);
        grant[PORT_DATA] = req_a[PORT_DATA] && !busy[PORT_DATA] && !d_block;
        c_block = hit_a[PORT_CODE]
               && ((busy[PORT_DATA] && hdev[PORT_DATA] == dev_a[PORT_CODE])
                || (grant[PORT_DATA] && hit_a[PORT_DATA]
                    && dev_a[PORT_DATA] == dev_a[PORT_CODE]));
        grant[PORT_CODE] = req_a[PORT_CODE] && !busy[PORT_CODE] && !c_block;
    end

    assign c_paddr = pa_a[PORT_CODE];
    assign c_dev   = dev_a[PORT_CODE];
    assign c_ext   = hit_a[PORT_CODE];
    assign c_ready = rdy[PORT_CODE];
    assign d_paddr = pa_a[PORT_DATA];
    assign d_dev   = dev_a[PORT_DATA];
    assign d_ext   = hit_a[PORT_DATA];
    assign d_ready = rdy[PORT_DATA];
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker #(
    parameter int LA_W  = 16,
    parameter int PA_W  = 24,
    parameter int DEV_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             c_req,
    input logic [LA_W-1:0]  c_laddr,
    input logic [PA_W-1:0]  c_paddr,
    input logic [DEV_W-1:0] c_dev,
    input logic             c_ext,
    input logic             c_ready,
    input logic             d_req,
    input logic [DEV_W-1:0] d_dev,
    input logic             d_ext,
    input logic             d_ready,
    input logic             c_busy,
    input logic             d_busy,
    input logic [DEV_W-1:0] c_hdev,
    input logic [DEV_W-1:0] d_hdev
);
    a_r1_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !c_ext |-> (c_dev == '0 && c_paddr == PA_W'(c_laddr)));

    a_r7_code_ready_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        c_ready |-> c_req);

    a_r7_data_ready_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        d_ready |-> d_req);

    a_r7_code_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        c_ready |=> !c_busy);

    a_r7_data_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        d_ready |=> !d_busy);

    a_r8_code_miss_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ext && !c_busy) |-> c_ready);

    a_r8_data_miss_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req && !d_ext && !d_busy) |-> d_ready);

    a_r9_data_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && d_req && c_ext && d_ext && c_dev == d_dev && !c_busy && !d_busy)
        |-> !c_ready);

    a_r10_device_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_busy && d_busy && c_hdev == d_hdev));
endmodule

bind win_xlate xlt_checker #(.LA_W(LA_W), .PA_W(PA_W), .DEV_W(DEV_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .c_req(c_req), .c_laddr(c_laddr), .c_paddr(c_paddr), .c_dev(c_dev),
    .c_ext(c_ext), .c_ready(c_ready),
    .d_req(d_req), .d_dev(d_dev), .d_ext(d_ext), .d_ready(d_ready),
    .c_busy(busy[0]), .d_busy(busy[1]), .c_hdev(hdev[0]), .d_hdev(hdev[1])
);

// File: tb/win_xlate_bench.sv
module win_xlate_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_port = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [1:0]  cfg_fld = '0;
    logic [31:0] cfg_wdata = '0;
    logic        c_req = 1'b0, d_req = 1'b0;
    logic [15:0] c_laddr = '0, d_laddr = '0;
    logic [23:0] c_paddr, d_paddr;
    logic [1:0]  c_dev, d_dev;
    logic        c_ext, d_ext, c_ready, d_ready;

    int nchk = 0, nerr = 0, cyc = 0, cstart = 0, dstart = 0;

    typedef struct {
        string       tag;
        logic [23:0] pa;
        logic [1:0]  dev;
        logic        ext;
        int          lat;
    } exp_t;
    exp_t cq[$];
    exp_t dq[$];
    exp_t ce, de;

    win_xlate u_win_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
        .cfg_idx(cfg_idx), .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
        .c_req(c_req), .c_laddr(c_laddr), .c_paddr(c_paddr), .c_dev(c_dev),
        .c_ext(c_ext), .c_ready(c_ready),
        .d_req(d_req), .d_laddr(d_laddr), .d_paddr(d_paddr), .d_dev(d_dev),
        .d_ext(d_ext), .d_ready(d_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cfg(bit port, int idx, int fld, logic [31:0] val);
        cfg_port = port; cfg_idx = idx[1:0]; cfg_fld = fld[1:0];
        cfg_wdata = val; cfg_we = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic win(bit port, int idx, logic [15:0] lb, logic [15:0] mk,
                       logic [23:0] pb, logic [31:0] ctrl);
        cfg(port, idx, 0, {16'h0, lb});
        cfg(port, idx, 1, {16'h0, mk});
        cfg(port, idx, 2, {8'h0, pb});
        cfg(port, idx, 3, ctrl);
    endtask

    // driver tasks: push the expectation, raise the request, hold until ready
    task automatic c_acc(string tag, logic [15:0] la, logic [23:0] pa,
                         logic [1:0] dv, logic ex, int lat);
        exp_t e;
        e.tag = tag; e.pa = pa; e.dev = dv; e.ext = ex; e.lat = lat;
        cq.push_back(e);
        c_laddr = la; c_req = 1'b1; cstart = cyc;
        do @(negedge clk); while (!c_ready);
        @(posedge clk); #1;
        c_req = 1'b0;
    endtask

    task automatic d_acc(string tag, logic [15:0] la, logic [23:0] pa,
                         logic [1:0] dv, logic ex, int lat);
        exp_t e;
        e.tag = tag; e.pa = pa; e.dev = dv; e.ext = ex; e.lat = lat;
        dq.push_back(e);
        d_laddr = la; d_req = 1'b1; dstart = cyc;
        do @(negedge clk); while (!d_ready);
        @(posedge clk); #1;
        d_req = 1'b0;
    endtask

    // monitor: compare each completion against the head of its port queue
    always @(negedge clk) begin
        if (rst_n && c_req && c_ready) begin
            if (cq.size() == 0) chk("fetch unexpected ready", 1, 0);
            else begin
                ce = cq.pop_front();
                chk({ce.tag, " fetch paddr"}, c_paddr, ce.pa);
                chk({ce.tag, " fetch dev"}, c_dev, ce.dev);
                chk({ce.tag, " fetch ext"}, c_ext, ce.ext);
                chk({ce.tag, " fetch latency"}, cyc - cstart, ce.lat);
            end
        end
        if (rst_n && d_req && d_ready) begin
            if (dq.size() == 0) chk("data unexpected ready", 1, 0);
            else begin
                de = dq.pop_front();
                chk({de.tag, " data paddr"}, d_paddr, de.pa);
                chk({de.tag, " data dev"}, d_dev, de.dev);
                chk({de.tag, " data ext"}, d_ext, de.ext);
                chk({de.tag, " data latency"}, cyc - dstart, de.lat);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        c_laddr = 16'h1234; d_laddr = 16'hBEEF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset leaves every window off
        chk("R1 fetch paddr", c_paddr, 24'h001234);
        chk("R1 fetch ext", c_ext, 0);
        chk("R1 data paddr", d_paddr, 24'h00BEEF);
        chk("R1 data dev", d_dev, 0);
        @(posedge clk); #1;
        c_acc("R8 miss", 16'h1234, 24'h001234, 2'd0, 1'b0, 0);

        // R11: ctrl = {en bit6, wait [5:2], dev [1:0]}
        win(0, 0, 16'h4000, 16'hF000, 24'h100000, 32'h4D); // dev1 wait3
        win(0, 1, 16'h4000, 16'hC000, 24'h200000, 32'h46); // dev2 wait1
        win(0, 2, 16'h8000, 16'h8000, 24'h500000, 32'h03); // disabled
        win(1, 0, 16'h4000, 16'hF000, 24'h300000, 32'h49); // dev1 wait2
        win(1, 1, 16'h9000, 16'hF000, 24'h400000, 32'h42); // dev2 wait0

        // R6: both translations visible in one cycle without req
        c_laddr = 16'h5010; d_laddr = 16'h9ABC;
        @(negedge clk);
        chk("R6 fetch paddr", c_paddr, 24'h201010);
        chk("R6 data paddr", d_paddr, 24'h400ABC);
        @(posedge clk); #1;

        c_acc("R3 overlap low index", 16'h4123, 24'h100123, 2'd1, 1'b1, 3);
        c_acc("R2 single window", 16'h5010, 24'h201010, 2'd2, 1'b1, 1);
        c_acc("R4 disabled window", 16'h8005, 24'h008005, 2'd0, 1'b0, 0);
        d_acc("R5 bank isolation miss", 16'h5010, 24'h005010, 2'd0, 1'b0, 0);
        d_acc("R5 data bank hit", 16'h4123, 24'h300123, 2'd1, 1'b1, 2);

        fork
            c_acc("R6 concurrent fetch", 16'h5010, 24'h201010, 2'd2, 1'b1, 1);
            d_acc("R6 concurrent data", 16'h4123, 24'h300123, 2'd1, 1'b1, 2);
        join
        fork
            c_acc("R9 tie fetch stalls", 16'h4123, 24'h100123, 2'd1, 1'b1, 6);
            d_acc("R9 tie data wins", 16'h4010, 24'h300010, 2'd1, 1'b1, 2);
        join
        fork
            d_acc("R10 data holds", 16'h4010, 24'h300010, 2'd1, 1'b1, 2);
            begin
                @(posedge clk); #1;
                c_acc("R10 fetch waits", 16'h4123, 24'h100123, 2'd1, 1'b1, 5);
            end
        join
        fork
            c_acc("R10 fetch holds", 16'h5010, 24'h201010, 2'd2, 1'b1, 1);
            begin
                @(posedge clk); #1;
                d_acc("R10 data waits", 16'h9ABC, 24'h400ABC, 2'd2, 1'b1, 1);
            end
        join

        cfg(0, 2, 3, 32'h43);   // enable dev3 wait0
        c_acc("R4 enabled window", 16'h8005, 24'h500005, 2'd3, 1'b1, 0);
        cfg(0, 1, 3, 32'h7E);   // dev2 wait15
        c_acc("R7 max wait", 16'h5010, 24'h201010, 2'd2, 1'b1, 15);
        cfg(0, 0, 3, 32'h0D);   // disable window 0
        c_acc("R3 next priority", 16'h4123, 24'h200123, 2'd2, 1'b1, 15);
        // R5: fetch bank changes left data bank intact
        d_acc("R5 data unchanged", 16'h4123, 24'h300123, 2'd1, 1'b1, 2);

        repeat (2) @(posedge clk);
        chk("R7 no leftover fetch", cq.size(), 0);
        chk("R7 no leftover data", dq.size(), 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule